// File: doc/BRIEF.md
# Latched-Address Inverting Line Decoder

This block turns a binary address into a set of mutually exclusive, active-low select lines. The address first passes a holding stage. While the hold control is low the stage is transparent and the selected line follows the live address. When hold goes high the stage keeps the address it saw in the last transparent cycle, and later address changes are ignored until hold drops again. Two enables of opposite polarity gate every output, whatever the address or the hold state.

The design is fully synchronous. Every input is sampled on the system clock, and the outputs are registered. A sample taken at clock edge k therefore shows up on the outputs after edge k+1. Each decoder stage handles `STAGE_W` address bits. `LEVELS` stages can be cascaded into a tree, where each upper-level output drives the active-low enable of one lower-level stage. The defaults (3 bits, 2 levels) give a 6-bit address and 64 select lines, with the address held at the block's input.

Top module: `ldec_latched`

## Requirements
- R1: At most one bit of `sel_n_o` is 0 at any time. Outputs are active low.
- R2: With `hold_i` sampled 0, the output reflects the address sampled in the same cycle, two clock edges after that address was driven.
- R3: When `hold_i` is sampled 1 after a cycle where it was sampled 0, the address kept is the one sampled in that preceding cycle (the last transparent sample). A new address presented together with the rising hold is not taken.
- R4: While `hold_i` stays sampled 1, changes on `addr_i` have no effect on `sel_n_o`.
- R5: All bits of `sel_n_o` are 1 unless `en_lo_i` is sampled 0 and `en_hi_i` is sampled 1.
- R6: Toggling either enable while held neither changes nor releases the kept address. When both enables are asserted again, the kept address is selected.
- R7: With both enables asserted, bit `sel_n_o[a]` is 0 for effective address `a` (`addr_i` bit 0 least significant), and all others are 1. In the cascade, the upper `STAGE_W` bits select a group of `2**STAGE_W` lines and the lower bits select the line within that group.
- R8: A synchronous active-high `rst` drives all outputs to 1, clears the kept address to 0 and leaves the stage transparent. If hold is raised in the first cycle after reset, line 0 is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | AW (=STAGE_W*LEVELS) | Binary address |
| hold_i | input | 1 | 0 = transparent, 1 = keep address |
| en_lo_i | input | 1 | Active-low enable |
| en_hi_i | input | 1 | Active-high enable |
| sel_n_o | output | 2**AW | Active-low select lines |

## Verification
The closing of the hold stage can coincide with an address change and with an enable change in the same sampled cycle. The bench provokes this by raising `hold_i` in the very cycle that `addr_i` moves to a new value and an enable drops. It also toggles enables repeatedly while the address is held. A reference model that keeps the last transparent address decides what the registered outputs must be. A scoreboard checks that the old address wins, that the gated cycles show all lines high, and that re-enabling brings back the kept line.

// File: rtl/ldec_pkg.sv
package ldec_pkg;

   // Sampled control word for the address-holding stage
   typedef struct packed {
      logic hold;    // 1 = keep address
      logic en_lo;   // active-low enable
      logic en_hi;   // active-high enable
   } ldec_ctl_t;

   localparam ldec_ctl_t LDEC_CTL_RESET = '{hold: 1'b0, en_lo: 1'b1, en_hi: 1'b0};

   function automatic logic ldec_gate_open(input ldec_ctl_t c);
      return (!c.en_lo) && c.en_hi;
   endfunction

endpackage

// File: rtl/ldec_addr_hold.sv
module ldec_addr_hold
   import ldec_pkg::*;
#(
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [AW-1:0] addr_i,
   input  ldec_ctl_t     ctl_i,
   output logic [AW-1:0] eff_o,
   output logic          open_o
);

   initial begin
      if (AW < 1) $error("ldec_addr_hold: AW must be at least 1");
   end

   logic [AW-1:0] addr_s;
   ldec_ctl_t     ctl_s;
   logic [AW-1:0] keep_q;
   logic          hold_d;
   logic          hold_rise;

   // Input sampling, plus the previous hold sample for edge detection
   always_ff @(posedge clk) begin
      if (rst) begin
         addr_s <= '0;
         ctl_s  <= LDEC_CTL_RESET;
         hold_d <= 1'b0;
      end else begin
         addr_s <= addr_i;
         ctl_s  <= ctl_i;
         hold_d <= ctl_s.hold;
      end
   end

   // Kept address follows the sampled address while transparent
   always_ff @(posedge clk) begin
      if (rst) begin
         keep_q <= '0;
      end else if (!ctl_s.hold) begin
         keep_q <= addr_s;
      end
   end

   assign hold_rise = ctl_s.hold && !hold_d;
   assign eff_o     = ctl_s.hold ? keep_q : addr_s;
   assign open_o    = ldec_gate_open(ctl_s);

   // R3: on the closing edge the kept value is the previous transparent sample
   p_capture_r3: assert property (@(posedge clk) disable iff (rst)
      hold_rise |-> (eff_o == $past(addr_s)));

   // R4: a continuing hold freezes the effective address
   p_freeze_r4: assert property (@(posedge clk) disable iff (rst)
      (ctl_s.hold && hold_d) |-> $stable(eff_o));

   // R6: enable activity while held leaves the kept address alone
   p_enkeep_r6: assert property (@(posedge clk) disable iff (rst)
      (ctl_s.hold && $past(ctl_s.hold) && !$stable(ctl_s.en_lo ^ ctl_s.en_hi))
      |-> $stable(keep_q));

endmodule

// File: rtl/ldec_stage.sv
module ldec_stage #(
   parameter int SW = 3,
   localparam int NY = 1 << SW
) (
   input  logic [SW-1:0] sel_i,
   input  logic          en_lo_i,
   input  logic          en_hi_i,
   output logic [NY-1:0] y_n_o
);

   initial begin
      if (SW < 1 || SW > 4) $error("ldec_stage: SW must lie in 1..4");
   end

   logic live;
   assign live = (!en_lo_i) && en_hi_i;

   for (genvar k = 0; k < NY; k++) begin : g_line
      assign y_n_o[k] = !(live && (sel_i == SW'(k)));
   end

endmodule

// File: rtl/ldec_tree.sv
module ldec_tree #(
   parameter int SW     = 3,
   parameter int LEVELS = 2,
   localparam int AW    = SW * LEVELS,
   localparam int NOUT  = 1 << AW
) (
   input  logic [AW-1:0]   sel_i,
   input  logic            en_lo_i,
   input  logic            en_hi_i,
   output logic [NOUT-1:0] y_n_o
);

   localparam int NS = 1 << SW;

   initial begin
      if (LEVELS < 1 || LEVELS > 3) $error("ldec_tree: LEVELS must lie in 1..3");
      if (AW > 10) $error("ldec_tree: total address width above 10");
   end

   for (genvar l = 0; l < LEVELS; l++) begin : g_lv
      localparam int NG = 1 << (SW * l);
      localparam int NL = NG * NS;
      logic [NL-1:0] y;

      for (genvar j = 0; j < NG; j++) begin : g_st
         logic gate_lo;
         logic gate_hi;
         if (l == 0) begin : g_root
            assign gate_lo = en_lo_i;
            assign gate_hi = en_hi_i;
         end else begin : g_leaf
            assign gate_lo = g_lv[l-1].y[j];
            assign gate_hi = 1'b1;
         end

         ldec_stage #(.SW(SW)) u_st (
            .sel_i   (sel_i[AW-1-SW*l -: SW]),
            .en_lo_i (gate_lo),
            .en_hi_i (gate_hi),
            .y_n_o   (y[j*NS +: NS])
         );
      end
   end

   assign y_n_o = g_lv[LEVELS-1].y;

endmodule

// File: rtl/ldec_latched.sv
module ldec_latched
   import ldec_pkg::*;
#(
   parameter int STAGE_W = 3,
   parameter int LEVELS  = 2,
   localparam int AW     = STAGE_W * LEVELS,
   localparam int NOUT   = 1 << AW
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [AW-1:0]   addr_i,
   input  logic            hold_i,
   input  logic            en_lo_i,
   input  logic            en_hi_i,
   output logic [NOUT-1:0] sel_n_o
);

   initial begin
      if (STAGE_W < 1 || STAGE_W > 4) $error("ldec_latched: STAGE_W must lie in 1..4");
      if (LEVELS < 1 || LEVELS > 3)   $error("ldec_latched: LEVELS must lie in 1..3");
      if (AW > 10)                    $error("ldec_latched: address wider than 10");
   end

   ldec_ctl_t       ctl;
   logic [AW-1:0]   eff;
   logic            open;
   logic [NOUT-1:0] dec_n;

   assign ctl = '{hold: hold_i, en_lo: en_lo_i, en_hi: en_hi_i};

   ldec_addr_hold #(.AW(AW)) u_hold (
      .clk    (clk),
      .rst    (rst),
      .addr_i (addr_i),
      .ctl_i  (ctl),
      .eff_o  (eff),
      .open_o (open)
   );

   // Single stage or cascaded tree
   if (LEVELS == 1) begin : g_flat
      ldec_stage #(.SW(STAGE_W)) u_dec (
         .sel_i   (eff),
         .en_lo_i (!open),
         .en_hi_i (1'b1),
         .y_n_o   (dec_n)
      );
   end else begin : g_cascade
      ldec_tree #(.SW(STAGE_W), .LEVELS(LEVELS)) u_dec (
         .sel_i   (eff),
         .en_lo_i (!open),
         .en_hi_i (1'b1),
         .y_n_o   (dec_n)
      );
   end

   always_ff @(posedge clk) begin
      if (rst) sel_n_o <= '1;
      else     sel_n_o <= dec_n;
   end

   // R1: never more than one line low
   p_onecold_r1: assert property (@(posedge clk) disable iff (rst)
      $onehot0(~sel_n_o));

   // R5: closed gate gives all lines high one edge later
   p_gate_r5: assert property (@(posedge clk) disable iff (rst)
      !$past(open) |-> (&sel_n_o));

   // R7: open gate selects exactly the effective address
   p_index_r7: assert property (@(posedge clk) disable iff (rst)
      $past(open) |-> ($countones(~sel_n_o) == 1 && !sel_n_o[$past(eff)]));

   // R8: first cycle after reset shows all lines high
   p_reset_r8: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (&sel_n_o));

endmodule

// File: tb/sim_ldec_latched.sv
module sim_ldec_latched;

   localparam int SW   = 3;
   localparam int LV   = 2;
   localparam int AW   = SW * LV;
   localparam int NOUT = 1 << AW;

   typedef struct {
      logic [NOUT-1:0] exp;
      string           tag;
   } item_t;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic [AW-1:0]   addr_i = '0;
   logic            hold_i = 1'b0;
   logic            en_lo_i = 1'b1;
   logic            en_hi_i = 1'b0;
   logic [NOUT-1:0] sel_n_o;

   int checks = 0;
   int errors = 0;
   item_t sb[$];
   logic [AW-1:0] m_keep = '0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ldec_latched #(.STAGE_W(SW), .LEVELS(LV)) u0 (
      .clk     (clk),
      .rst     (rst),
      .addr_i  (addr_i),
      .hold_i  (hold_i),
      .en_lo_i (en_lo_i),
      .en_hi_i (en_hi_i),
      .sel_n_o (sel_n_o)
   );

   task automatic drive(input logic [AW-1:0] a, input logic h,
                        input logic elo, input logic ehi, input string tag);
      item_t it;
      logic [AW-1:0] use_a;
      @(negedge clk);
      rst = 1'b0; addr_i = a; hold_i = h; en_lo_i = elo; en_hi_i = ehi;
      use_a = h ? m_keep : a;
      if (!h) m_keep = a;
      it.exp = (!elo && ehi) ? ~(NOUT'(1) << use_a) : '1;
      it.tag = tag;
      sb.push_back(it);
   endtask

   // Monitor: compares two edges after each drive
   always begin
      @(posedge clk);
      #5;
      if (sb.size() >= 2) begin
         item_t it;
         it = sb.pop_front();
         checks++;
         if (sel_n_o !== it.exp) begin
            errors++;
            $display("FAIL %s: sel_n_o=%h expected=%h", it.tag, sel_n_o, it.exp);
         end
      end
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         errors++;
         $display("FAIL watchdog: cycles=%0d expected below %0d", cyc, 20000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R8: outputs held high during reset even with enables asserted
      addr_i = 6'd5; en_lo_i = 1'b0; en_hi_i = 1'b1;
      repeat (4) @(negedge clk);
      checks++;
      if (sel_n_o !== '1) begin
         errors++;
         $display("FAIL R8: sel_n_o=%h expected=%h", sel_n_o, {NOUT{1'b1}});
      end

      // R8: hold right after reset keeps address 0
      drive(6'd9,  1'b1, 1'b0, 1'b1, "R8");
      drive(6'd41, 1'b1, 1'b0, 1'b1, "R8");

      // R2 R7 R1: transparent sweep of every address
      for (int a = 0; a < NOUT; a++) drive(AW'(a), 1'b0, 1'b0, 1'b1, "R7");

      // R5: every enable combination over a few addresses
      for (int e = 0; e < 4; e++)
         for (int a = 0; a < NOUT; a += 13)
            drive(AW'(a), 1'b0, e[0], e[1], "R5");

      // R3: hold rises in the same cycle the address and an enable move
      drive(6'd37, 1'b0, 1'b0, 1'b1, "R2");
      drive(6'd12, 1'b1, 1'b1, 1'b1, "R3");
      drive(6'd12, 1'b1, 1'b0, 1'b1, "R3");

      // R4: address sweep while held
      for (int a = 0; a < NOUT; a += 5) drive(AW'(a), 1'b1, 1'b0, 1'b1, "R4");

      // R6: enable toggling while held, then re-enable
      for (int k = 0; k < 8; k++)
         drive(AW'(k * 7), 1'b1, k[0], k[1], "R6");
      drive(6'd0, 1'b1, 1'b0, 1'b1, "R6");

      // R2: release follows the live address again
      drive(6'd63, 1'b0, 1'b0, 1'b1, "R2");
      drive(6'd8,  1'b0, 1'b0, 1'b1, "R2");

      // Mixed traffic covering all functions
      for (int k = 0; k < 400; k++) begin
         logic [AW-1:0] a;
         logic h, elo, ehi;
         a   = AW'($urandom_range(NOUT - 1));
         h   = ($urandom_range(3) != 0);
         elo = ($urandom_range(4) == 0);
         ehi = ($urandom_range(4) != 0);
         drive(a, h, elo, ehi, "R1");
      end

      // Drain the scoreboard
      drive(6'd0, 1'b0, 1'b1, 1'b0, "R5");
      drive(6'd0, 1'b0, 1'b1, 1'b0, "R5");
      repeat (3) @(negedge clk);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule